// File: doc/BRIEF.md
# PWM Output High-Impedance Protection Controller

This block guards the six switching outputs of a motor-inverter PWM timer. Two fault sources each force a group of outputs into high impedance. Each source is taken either from an external shutdown pin or from an internal comparator output. The PWM generator and the analog comparators sit outside the block. The block sees only the digital fault levels, one period tick from each of the two master channels, a software release strobe, and the enable and run status of the timer.

A 16-bit mode word chooses among four policies:

- **Six-phase:** every output from 2 to 7 is protected together.
- **Half-bridge:** source 0 guards outputs 2 and 3, and source 1 guards outputs 6 and 7.
- **Two-stage over-current:** a light fault releases on its own, and a heavy fault needs a software release.
- **Over-current / back-EMF:** source 0 is active low.

A group is never released at once. Release waits for the next period tick of that group's master channel, and the tick only counts once a release condition has been armed. The arming condition is either the fault's inactive edge or a software strobe.

The mode word is locked against writes unless both group enables are off and both master channels are stopped. Each fault passes through a two-flop synchroniser and an edge detector. The per-group state drives a per-channel high-impedance enable and a status flag.

Top module: `hiz_guard`

## Requirements
- R1: After reset the mode word reads 0000H, every high-impedance enable is 0 and both group status flags are 0.
- R2: A mode write replaces all 16 bits. It takes effect only while `grp_en` is 00 and `mst_run` is 00. A write at any other time leaves `mode_rd` unchanged.
- R3: Bit 4 of the mode word picks the fault sources: 0 selects `ext_flt`, 1 selects `cmp_flt`. The unselected inputs have no effect on the outputs.
- R4: An active edge on an enabled source sets its group. The affected `hiz_out` bits read 1 after the third rising clock edge that follows the input change, and not after the second.
- R5: Mode bits [1:0] = 0 is six-phase: `hiz_out[7:2]` are all 1 while either group is set. `hiz_out[1:0]` are 0 in every mode.
- R6: Mode bits [1:0] = 1 is half-bridge: group 0 drives `hiz_out[3:2]`, group 1 drives `hiz_out[7:6]`, and `hiz_out[5:4]` stay 0.
- R7: Under the edge release method, a set group clears on the first `per_tick` of its own master channel after the fault's inactive edge. Group 0 uses `per_tick[0]` and group 1 uses `per_tick[1]`. Ticks of the other channel have no effect.
- R8: Under the software release method, a set group clears on the first own-channel tick after a `sw_rel` pulse. Ticks without a prior pulse do not clear it. Bit 5 selects the method in six-phase mode and bit 6 selects it in half-bridge mode; in both, 0 means edge release and 1 means software release.
- R9: Mode bits [1:0] = 2 is two-stage: group 0 uses edge release, group 1 uses software release, and outputs 2 to 7 are all driven by either group.
- R10: Mode bits [1:0] = 3 is over-current / back-EMF: source 0 is active low, source 1 is active high, and both groups use edge release. Outputs 2 to 7 are driven by either group.
- R11: A release tick that arrives while the group's fault level is still active is ignored. The group stays set and its armed release waits for a later tick.
- R12: While `grp_en[k]` is 0, group k never sets and is cleared one cycle after the bit drops. With both bits 0, no output is in high impedance.
- R13: `grp_stat[k]` is 1 exactly while group k is in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_flt | input | 2 | External shutdown pin levels, one per source |
| cmp_flt | input | 2 | Internal comparator output levels, one per source |
| per_tick | input | 2 | Period-boundary pulse from master channel 0 (bit 0) and 4 (bit 1) |
| sw_rel | input | 1 | Software release strobe |
| grp_en | input | 2 | High-impedance enable per group |
| mst_run | input | 2 | Master channel running flags |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 16 | Mode word write data |
| hiz_out | output | 8 | Per-channel high-impedance enable |
| grp_stat | output | 2 | Group-in-high-impedance status |
| mode_rd | output | 16 | Current mode word |

## Verification
The central collision is a period tick that would complete an armed release landing in the same cycle as a fault level that is still active. The bench arms a software release while the fault is held high, then fires the group's own tick. It expects the outputs to remain in high impedance. It then drops the fault, waits out the synchroniser, and ticks again, expecting release without a second strobe. The same scenarios also fire the other channel's tick and stray ticks before any arming, and judge that neither releases the group.

// File: rtl/hiz_pkg.sv
package hiz_pkg;
    localparam int NUM_SRC     = 2;
    localparam int NUM_OUT     = 8;
    localparam int MODE_LSB    = 0;
    localparam int MODE_W      = 2;
    localparam int SEL_BIT     = 4;
    localparam int SIX_SW_BIT  = 5;
    localparam int HALF_SW_BIT = 6;
    localparam int G0_LO       = 2;
    localparam int G1_LO       = 6;
    localparam int PAIR_W      = 2;
    localparam int ALL_LO      = 2;
    localparam int ALL_W       = NUM_OUT - ALL_LO;

    typedef enum logic [MODE_W-1:0] {
        MD_SIX   = 2'd0,
        MD_HALF  = 2'd1,
        MD_TWO   = 2'd2,
        MD_OCEMF = 2'd3
    } hiz_mode_e;
endpackage

// File: rtl/hiz_flt_edge.sv
module hiz_flt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic inv,
    output logic lvl,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic cur_lvl, old_lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], raw};
        st_d.prev = st_q.sync[STAGES-1];
        cur_lvl   = st_q.sync[STAGES-1] ^ inv;
        old_lvl   = st_q.prev ^ inv;
        lvl       = cur_lvl;
        rise      = cur_lvl & ~old_lvl;
        fall      = ~cur_lvl & old_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: an edge event lasts a single cycle
    a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/hiz_grp_ctl.sv
module hiz_grp_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_ev,
    input  logic fall_ev,
    input  logic lvl,
    input  logic use_sw,
    input  logic sw_rel,
    input  logic tick,
    output logic hiz
);
    typedef struct packed {
        logic hiz;
        logic pend;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic    arm;

    always_comb begin
        st_d = st_q;
        arm  = use_sw ? sw_rel : fall_ev;
        if (!en) begin
            st_d = '0;
        end else if (set_ev) begin
            st_d.hiz  = 1'b1;
            st_d.pend = 1'b0;
        end else if (st_q.hiz) begin
            if (st_q.pend && tick && !lvl) begin
                st_d = '0;
            end else if (arm) begin
                st_d.pend = 1'b1;
            end
        end
        hiz = st_q.hiz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r12_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hiz);
    a_r4_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_ev) |=> hiz);
    a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hiz) |-> ($past(tick) || !$past(en)));
    a_r11_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hiz && lvl) |=> hiz);
endmodule

// File: rtl/hiz_mode_reg.sv
module hiz_mode_reg #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [1:0]       grp_en,
    input  logic [1:0]       mst_run,
    output logic [REG_W-1:0] mode
);
    typedef struct packed {
        logic [REG_W-1:0] word;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic     unlocked;

    always_comb begin
        st_d     = st_q;
        unlocked = ~|grp_en & ~|mst_run;
        if (we && unlocked) st_d.word = wdata;
        mode = st_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (|grp_en || |mst_run)) |=> $stable(mode));
    a_r2_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(|grp_en) && !(|mst_run)) |=> (mode == $past(wdata)));
endmodule

// File: rtl/hiz_guard.sv
module hiz_guard
    import hiz_pkg::*;
#(
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ext_flt,
    input  logic [NUM_SRC-1:0] cmp_flt,
    input  logic [NUM_SRC-1:0] per_tick,
    input  logic               sw_rel,
    input  logic [NUM_SRC-1:0] grp_en,
    input  logic [NUM_SRC-1:0] mst_run,
    input  logic               mode_we,
    input  logic [REG_W-1:0]   mode_wdata,
    output logic [NUM_OUT-1:0] hiz_out,
    output logic [NUM_SRC-1:0] grp_stat,
    output logic [REG_W-1:0]   mode_rd
);
    hiz_mode_e        md;
    logic             sel_cmp;
    logic [NUM_SRC-1:0] raw, inv, lvl, rise, fall, use_sw, grp;

    hiz_mode_reg #(.REG_W(REG_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mode_we),
        .wdata   (mode_wdata),
        .grp_en  (grp_en),
        .mst_run (mst_run),
        .mode    (mode_rd)
    );

    assign md      = hiz_mode_e'(mode_rd[MODE_LSB +: MODE_W]);
    assign sel_cmp = mode_rd[SEL_BIT];

    always_comb begin
        case (md)
            MD_SIX:  use_sw = {NUM_SRC{mode_rd[SIX_SW_BIT]}};
            MD_HALF: use_sw = {NUM_SRC{mode_rd[HALF_SW_BIT]}};
            MD_TWO:  use_sw = 2'b10;
            default: use_sw = 2'b00;
        endcase
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign raw[k] = sel_cmp ? cmp_flt[k] : ext_flt[k];
        assign inv[k] = (k == 0) && (md == MD_OCEMF);

        hiz_flt_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw[k]),
            .inv   (inv[k]),
            .lvl   (lvl[k]),
            .rise  (rise[k]),
            .fall  (fall[k])
        );

        hiz_grp_ctl u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (grp_en[k]),
            .set_ev  (rise[k]),
            .fall_ev (fall[k]),
            .lvl     (lvl[k]),
            .use_sw  (use_sw[k]),
            .sw_rel  (sw_rel),
            .tick    (per_tick[k]),
            .hiz     (grp[k])
        );
    end

    always_comb begin
        hiz_out = '0;
        if (md == MD_HALF) begin
            hiz_out[G0_LO +: PAIR_W] = {PAIR_W{grp[0]}};
            hiz_out[G1_LO +: PAIR_W] = {PAIR_W{grp[1]}};
        end else begin
            hiz_out[ALL_LO +: ALL_W] = {ALL_W{|grp}};
        end
        grp_stat = grp;
    end

    a_r5_low_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_out[1:0] == 2'b00);
    a_r6_mid_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_HALF) |-> (hiz_out[5:4] == 2'b00));
    a_r12_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en == 2'b00) |=> (hiz_out == '0));
    a_r13_status_match: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_stat == 2'b00) |-> (hiz_out == '0));
endmodule

// File: tb/sim_hiz_guard.sv
module sim_hiz_guard;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_flt = '0, cmp_flt = '0, per_tick = '0, grp_en = '0, mst_run = '0;
    logic        sw_rel = 1'b0, mode_we = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic [7:0]  hiz_out;
    logic [1:0]  grp_stat;
    logic [15:0] mode_rd;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiz_guard u0 (
        .clk(clk), .rst_n(rst_n), .ext_flt(ext_flt), .cmp_flt(cmp_flt),
        .per_tick(per_tick), .sw_rel(sw_rel), .grp_en(grp_en), .mst_run(mst_run),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .hiz_out(hiz_out), .grp_stat(grp_stat), .mode_rd(mode_rd)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        per_tick[k] = 1'b1;
        cyc(1);
        per_tick[k] = 1'b0;
    endtask

    task automatic swr();
        sw_rel = 1'b1;
        cyc(1);
        sw_rel = 1'b0;
    endtask

    task automatic idle();
        grp_en = 2'b00; mst_run = 2'b00;
        ext_flt = '0; cmp_flt = '0;
        cyc(4);
    endtask

    task automatic wr_mode(input logic [15:0] v);
        mode_we = 1'b1; mode_wdata = v;
        cyc(1);
        mode_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_rd, 16'h0000);
        chk("R1 hiz", {8'h0, hiz_out}, 16'h0000);
        chk("R1 stat", {14'h0, grp_stat}, 16'h0000);
    endtask

    task automatic t_mode_write();
        grp_en = 2'b01;
        wr_mode(16'h1234);
        chk("R2 locked by enable", mode_rd, 16'h0000);
        grp_en = 2'b00; mst_run = 2'b10;
        wr_mode(16'h5678);
        chk("R2 locked by run", mode_rd, 16'h0000);
        mst_run = 2'b00;
        wr_mode(16'hBEEF);
        chk("R2 open write", mode_rd, 16'hBEEF);
        wr_mode(16'h0000);
        chk("R2 write back", mode_rd, 16'h0000);
    endtask

    task automatic t_six_edge();
        idle(); wr_mode(16'h0000); grp_en = 2'b11; cyc(1);
        ext_flt[0] = 1'b1;
        cyc(2);
        chk("R4 not after two edges", {8'h0, hiz_out}, 16'h0000);
        cyc(1);
        chk("R4 R5 six-phase set", {8'h0, hiz_out}, 16'h00FC);
        chk("R13 stat group0", {14'h0, grp_stat}, 16'h0001);
        ext_flt[0] = 1'b0;
        cyc(4);
        chk("R7 held without tick", {8'h0, hiz_out}, 16'h00FC);
        tick(1);
        chk("R7 other channel tick", {8'h0, hiz_out}, 16'h00FC);
        tick(0);
        chk("R7 released on own tick", {8'h0, hiz_out}, 16'h0000);
        chk("R13 stat cleared", {14'h0, grp_stat}, 16'h0000);
    endtask

    task automatic t_six_sw();
        idle(); wr_mode(16'h0020); grp_en = 2'b11; cyc(1);
        ext_flt[1] = 1'b1; cyc(3);
        chk("R13 stat group1", {14'h0, grp_stat}, 16'h0002);
        ext_flt[1] = 1'b0; cyc(4);
        tick(1);
        chk("R8 tick without strobe", {8'h0, hiz_out}, 16'h00FC);
        swr(); tick(1);
        chk("R8 released after strobe", {8'h0, hiz_out}, 16'h0000);
        ext_flt[1] = 1'b1; cyc(3);
        swr(); tick(1);
        chk("R11 fault active at tick", {8'h0, hiz_out}, 16'h00FC);
        ext_flt[1] = 1'b0; cyc(3);
        tick(1);
        chk("R11 armed release later", {8'h0, hiz_out}, 16'h0000);
    endtask

    task automatic t_half();
        idle(); wr_mode(16'h0001); grp_en = 2'b11; cyc(1);
        ext_flt[0] = 1'b1; cyc(3);
        chk("R6 group0 pair", {8'h0, hiz_out}, 16'h000C);
        ext_flt[1] = 1'b1; cyc(3);
        chk("R6 both pairs", {8'h0, hiz_out}, 16'h00CC);
        ext_flt = 2'b00; cyc(4);
        tick(0);
        chk("R6 R7 group0 released", {8'h0, hiz_out}, 16'h00C0);
        tick(1);
        chk("R6 R7 group1 released", {8'h0, hiz_out}, 16'h0000);
        idle(); wr_mode(16'h0041); grp_en = 2'b11; cyc(1);
        ext_flt[0] = 1'b1; cyc(3);
        ext_flt[0] = 1'b0; cyc(4);
        tick(0);
        chk("R8 half-bridge needs strobe", {8'h0, hiz_out}, 16'h000C);
        swr(); tick(0);
        chk("R8 half-bridge strobe release", {8'h0, hiz_out}, 16'h0000);
    endtask

    task automatic t_select();
        idle(); wr_mode(16'h0010); grp_en = 2'b11; cyc(1);
        ext_flt[0] = 1'b1; cyc(4);
        chk("R3 unselected pin ignored", {8'h0, hiz_out}, 16'h0000);
        ext_flt[0] = 1'b0;
        cmp_flt[0] = 1'b1; cyc(3);
        chk("R3 comparator selected", {8'h0, hiz_out}, 16'h00FC);
        cmp_flt[0] = 1'b0; cyc(4);
        tick(0);
        chk("R3 comparator release", {8'h0, hiz_out}, 16'h0000);
    endtask

    task automatic t_two_stage();
        idle(); wr_mode(16'h0002); grp_en = 2'b11; cyc(1);
        ext_flt[1] = 1'b1; cyc(3);
        chk("R9 heavy fault set", {6'h0, grp_stat, hiz_out}, 16'h02FC);
        ext_flt[1] = 1'b0; cyc(4);
        tick(1);
        chk("R9 heavy needs strobe", {8'h0, hiz_out}, 16'h00FC);
        swr(); tick(1);
        chk("R9 heavy released", {8'h0, hiz_out}, 16'h0000);
        ext_flt[0] = 1'b1; cyc(3);
        chk("R9 light fault set", {6'h0, grp_stat, hiz_out}, 16'h01FC);
        ext_flt[0] = 1'b0; cyc(4);
        tick(0);
        chk("R9 light edge release", {8'h0, hiz_out}, 16'h0000);
    endtask

    task automatic t_ocemf();
        idle(); ext_flt[0] = 1'b1; wr_mode(16'h0003); cyc(3);
        grp_en = 2'b11; cyc(2);
        chk("R10 idle high no fault", {8'h0, hiz_out}, 16'h0000);
        ext_flt[0] = 1'b0; cyc(3);
        chk("R10 low-side active low", {6'h0, grp_stat, hiz_out}, 16'h01FC);
        ext_flt[0] = 1'b1; cyc(4);
        tick(0);
        chk("R10 low-side released", {8'h0, hiz_out}, 16'h0000);
        ext_flt[1] = 1'b1; cyc(3);
        chk("R10 high-side active high", {6'h0, grp_stat, hiz_out}, 16'h02FC);
        ext_flt[1] = 1'b0; cyc(4);
        tick(1);
        chk("R10 high-side released", {8'h0, hiz_out}, 16'h0000);
    endtask

    task automatic t_enable();
        idle(); wr_mode(16'h0000); grp_en = 2'b01; cyc(1);
        ext_flt[1] = 1'b1; cyc(4);
        chk("R12 disabled group ignored", {6'h0, grp_stat, hiz_out}, 16'h0000);
        ext_flt[0] = 1'b1; cyc(3);
        chk("R12 enabled group sets", {6'h0, grp_stat, hiz_out}, 16'h01FC);
        grp_en = 2'b00; cyc(1);
        chk("R12 cleared on disable", {6'h0, grp_stat, hiz_out}, 16'h0000);
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_mode_write();
        t_six_edge();
        t_six_sw();
        t_half();
        t_select();
        t_two_stage();
        t_ocemf();
        t_enable();
        idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule